// File: doc/BRIEF.md
# Bus Interrupt Request Generator

This block lets software raise one of several prioritized bus interrupt request lines. Software writes a small level code into a register. Code zero means no request. A nonzero code n drives request line n high. That line stays high until one of two things happens: an interrupt acknowledge arrives, or software writes zero.

Software can read the code back at any time. Polling it shows whether the request has been acknowledged yet, because the acknowledge clears the code to zero. The request outputs come straight from flip-flops, so they never glitch, and at most one of them is high at a time.

The block does not decode the bus acknowledge cycle and does not supply a status/ID vector. It only consumes a one-cycle acknowledge pulse.

Top module: `irqgen_top`

## Requirements
- R1: After reset, the level code reads 0 and every request output is low.
- R2: A write whose low three data bits are 000 leaves every request output low from the next clock edge on.
- R3: A write whose low three data bits hold n (1 to 7) drives only `irq_o[n-1]` high from the next clock edge. For example, code 001 drives `irq_o[0]` and code 010 drives `irq_o[1]`.
- R4: When `ack_i` is high and no write is made, the code becomes 0 and all request outputs go low at the next edge. An acknowledge with no request pending leaves everything at 0.
- R5: Writing 0 while a request is pending drops that request at the next edge.
- R6: When a write and an acknowledge occur in the same cycle, the written code takes effect and the acknowledge is ignored.
- R7: `rd_data[2:0]` always shows the current level code, and `rd_data[7:3]` always reads 0.
- R8: At most one request output is high in any cycle.
- R9: Writing a new nonzero code while another request is pending moves the request to the new line at the next edge, with no idle cycle in between.
- R10: Without a write or an acknowledge, the code and the request outputs hold their values.
- R11: Write data bits 7 to 3 are ignored. Only bits 2 to 0 set the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 8 | Write data; bits 2:0 hold the level code |
| ack_i | input | 1 | Interrupt acknowledge pulse |
| rd_data | output | 8 | Readback: the level code in bits 2:0, zeros above |
| irq_o | output | 7 | Active-high request lines; bit n-1 is level n |

## Verification
The bench walks all seven nonzero codes so that each code is shown to reach exactly its own line and no neighbour. It also writes zero codes and codes with the upper data bits set, which separates the code field from the ignored bits. Three event patterns distinguish how the clear works: an acknowledge alone, a zero write alone, and a write and an acknowledge in the same cycle, which shows write priority. Back-to-back nonzero writes and idle cycles separate an immediate level change from simply holding the current state.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;

    // Defaults shared by the generator and its checker
    localparam int unsigned DEF_LEVELS = 7;
    localparam int unsigned DEF_REG_W  = 8;

    // What happens to the level code in a given cycle
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_ACK   = 2'd1,
        EV_WRITE = 2'd2
    } irq_evt_e;

endpackage

// File: rtl/irqgen_arb.sv
// Classifies the cycle's inputs into one event; a write outranks an acknowledge.
module irqgen_arb
    import irqgen_pkg::*;
(
    input  logic     wr_en,
    input  logic     ack_i,
    output irq_evt_e evt_o
);

    always_comb begin
        if (wr_en) begin
            evt_o = EV_WRITE;
        end else if (ack_i) begin
            evt_o = EV_ACK;
        end else begin
            evt_o = EV_IDLE;
        end
    end

endmodule

// File: rtl/irqgen_field.sv
// Holds the level code and computes its next value.
module irqgen_field
    import irqgen_pkg::*;
#(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irq_evt_e          evt_i,
    input  logic [CODE_W-1:0] wr_code_i,
    output logic [CODE_W-1:0] code_q_o,
    output logic [CODE_W-1:0] code_d_o
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } field_t;

    field_t st_d;
    field_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (evt_i)
            EV_WRITE: st_d.code = wr_code_i;
            EV_ACK:   st_d.code = '0;
            default:  st_d.code = st_q.code;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_q_o = st_q.code;
    assign code_d_o = st_d.code;

endmodule

// File: rtl/irqgen_decode.sv
// Decodes the next level code into registered one-hot request lines.
module irqgen_decode #(
    parameter int unsigned LEVELS = 7,
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_d_i,
    output logic [LEVELS-1:0] irq_o
);

    typedef struct packed {
        logic [LEVELS-1:0] lines;
    } dec_t;

    dec_t dec_d;
    dec_t dec_q;

    // One comparator per line; a code above LEVELS selects no line
    for (genvar g = 0; g < LEVELS; g++) begin : g_line
        assign dec_d.lines[g] = (code_d_i == CODE_W'(g + 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign irq_o = dec_q.lines;

endmodule

// File: rtl/irqgen_top.sv
module irqgen_top
    import irqgen_pkg::*;
#(
    parameter int unsigned LEVELS = DEF_LEVELS,
    parameter int unsigned REG_W  = DEF_REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ack_i,
    output logic [REG_W-1:0]  rd_data,
    output logic [LEVELS-1:0] irq_o
);

    localparam int unsigned CODE_W = $clog2(LEVELS + 1);

    irq_evt_e          evt;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;

    irqgen_arb u_arb (
        .wr_en (wr_en),
        .ack_i (ack_i),
        .evt_o (evt)
    );

    irqgen_field #(.CODE_W(CODE_W)) u_field (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .wr_code_i (wr_data[CODE_W-1:0]),
        .code_q_o  (code_q),
        .code_d_o  (code_d)
    );

    irqgen_decode #(.LEVELS(LEVELS), .CODE_W(CODE_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_d_i (code_d),
        .irq_o    (irq_o)
    );

    // Readback: the level code in the low bits, zeros above
    assign rd_data = {{(REG_W - CODE_W){1'b0}}, code_q};

endmodule

// File: rtl/irqgen_chk.sv
module irqgen_chk #(
    parameter int unsigned LEVELS = 7,
    parameter int unsigned REG_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic              ack_i,
    input logic [REG_W-1:0]  rd_data,
    input logic [LEVELS-1:0] irq_o
);

    localparam int unsigned CODE_W = $clog2(LEVELS + 1);

    function automatic logic [LEVELS-1:0] line_of(input logic [REG_W-1:0] r);
        line_of = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (r[CODE_W-1:0] == CODE_W'(i + 1)) line_of[i] = 1'b1;
        end
    endfunction

    // R8
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    // R3: lines agree with the readback code
    p_line_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == line_of(rd_data));

    // R4
    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !wr_en) |=> (rd_data == '0 && irq_o == '0));

    // R6 / R11: a write sets the code whatever ack does
    p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[CODE_W-1:0] == $past(wr_data[CODE_W-1:0]));

    // R7
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:CODE_W] == '0);

    // R10
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ack_i) |=> ($stable(rd_data) && $stable(irq_o)));

endmodule

bind irqgen_top irqgen_chk #(.LEVELS(LEVELS), .REG_W(REG_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ack_i   (ack_i),
    .rd_data (rd_data),
    .irq_o   (irq_o)
);

// File: tb/irqgen_top_tb_top.sv
`timescale 1ns/1ps
module irqgen_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ack_i = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] irq_o;

    always #2 clk = ~clk;

    irqgen_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ack_i   (ack_i),
        .rd_data (rd_data),
        .irq_o   (irq_o)
    );

    typedef struct {
        int         req;
        logic [7:0] rd;
        logic [6:0] irq;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    logic [2:0] model = '0;
    bit   done = 0;

    function automatic logic [6:0] vec(input logic [2:0] c);
        return (c == 3'd0) ? 7'd0 : (7'd1 << (c - 3'd1));
    endfunction

    task automatic push_exp(input int req);
        exp_t e;
        e.req = req;
        e.rd  = {5'b0, model};
        e.irq = vec(model);
        q.push_back(e);
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic a, input int req);
        @(negedge clk);
        wr_en = w; wr_data = d; ack_i = a;
        @(posedge clk);
        #1;
        wr_en = 1'b0; ack_i = 1'b0;
        if (w)      model = d[2:0];
        else if (a) model = 3'd0;
        push_exp(req);
    endtask

    // Monitor: compares queued expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (rd_data !== e.rd || irq_o !== e.irq) begin
                    n_bad++;
                    $display("FAIL R%0d: rd=%h irq=%b expected rd=%h irq=%b",
                             e.req, rd_data, irq_o, e.rd, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push_exp(1);                            // R1 reset state
        step(1'b1, 8'h03, 1'b0, 3);             // R3 code 3, R7 readback
        step(1'b0, 8'h00, 1'b0, 10);            // R10 hold
        step(1'b0, 8'h00, 1'b0, 10);            // R10 hold
        step(1'b0, 8'h00, 1'b1, 4);             // R4 ack clears
        step(1'b1, 8'h00, 1'b0, 2);             // R2 write zero
        for (int n = 1; n < 8; n++) begin
            step(1'b1, 8'(n), 1'b0, 3);         // R3 each line, R8 one-hot
            step(1'b0, 8'h00, 1'b0, 8);         // R8
        end
        step(1'b1, 8'h05, 1'b0, 9);             // R9 replace pending
        step(1'b1, 8'h02, 1'b0, 9);             // R9
        step(1'b1, 8'h00, 1'b0, 5);             // R5 zero drops request
        step(1'b1, 8'h06, 1'b1, 6);             // R6 write beats ack
        step(1'b1, 8'h00, 1'b1, 6);             // R6 zero write with ack
        step(1'b1, 8'hF9, 1'b0, 11);            // R11 upper bits ignored
        step(1'b0, 8'h00, 1'b0, 7);             // R7 upper readback zero
        step(1'b1, 8'hA8, 1'b0, 11);            // R11 upper only -> code 0
        step(1'b0, 8'h00, 1'b1, 4);             // R4 ack while idle
        step(1'b1, 8'h07, 1'b0, 3);             // R3 top line
        step(1'b0, 8'h00, 1'b1, 4);             // R4 ack clears line 7
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule